// File: doc/BRIEF.md
# Flash Program/Erase Status Polling Generator

This block produces the status a parallel NOR flash bank drives on its upper data pins while an internal program or erase algorithm runs. A command-sequence tracker sends it a single start pulse on the last write of a program or erase command. The pulse carries a protected-sector flag and, for a program, the three upper bits of the word being written. The block then holds the bank busy for a parameterised number of timebase ticks. While the bank is busy, each read strobe returns polling status instead of array contents.

There are three status bits. The poll bit tells the host whether the algorithm has finished. The toggle bit flips on every read while the algorithm runs. The time-limit bit goes high when an algorithm cannot finish within its allowed window. An operation that targets a protected sector does not touch the stored word. It only holds a short busy window and then returns the bank to read mode. In read mode a read returns the stored upper bits. These are all ones after reset or after an erase, and the programmed value after a program.

Top module: `flash_poll_status`

## Requirements
- R1: After reset, busy_o is 0 and dq7_o, dq6_o and dq5_o are 0. The stored word is all ones, so the first read returns 1 on all three pins.
- R2: A start is accepted only when the bank is idle, and busy_o rises in the cycle after the accepted pulse. If prog_start_i and erase_start_i are high together, the program request wins.
- R3: A read during a program returns the inverse of wdata_hi_i[2] (data bit 7) on dq7_o. The value used is the one latched with the accepted pulse.
- R4: A read during an erase returns 0 on dq7_o when rd_in_erase_i is 1, and 1 when rd_in_erase_i is 0.
- R5: The toggle state is cleared when a start is accepted. Each read while busy flips it and returns the new value on dq6_o, so the first read of an operation returns 1.
- R6: The bank stays busy for exactly PROG_TICKS (program), SECT_ERASE_TICKS (sector erase) or CHIP_ERASE_TICKS (chip erase, erase_chip_i=1) cycles in which tick_i is high. Cycles with tick_i low do not count.
- R7: If sect_prot_i was high at the accepted pulse, busy lasts PROT_PROG_TICKS or PROT_ERASE_TICKS ticks. The stored word is unchanged and verify_fail_i has no effect.
- R8: The first read after busy falls returns true data. After a program, dq7_o/dq6_o/dq5_o equal wdata_hi_i[2]/[1]/[0]. After an erase all three are 1.
- R9: In read mode, successive reads return the same stored bits, and dq6_o does not toggle.
- R10: If verify_fail_i is high during an unprotected operation, busy_o stays high until reset. A read issued once LIMIT_TICKS ticks have elapsed returns dq5_o=1; earlier reads return 0.
- R11: dq7_o, dq6_o and dq5_o change only in the cycle after a read strobe (rd_i high).
- R12: Start pulses that arrive while busy are ignored. They do not change the operation type, the latched data or the duration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_start_i | input | 1 | Program command completed (final write pulse) |
| erase_start_i | input | 1 | Erase command completed (final write pulse) |
| erase_chip_i | input | 1 | With erase_start_i: whole-chip erase instead of sector |
| sect_prot_i | input | 1 | Target sector(s) protected |
| verify_fail_i | input | 1 | Array verify keeps failing; algorithm cannot finish |
| wdata_hi_i | input | 3 | Data bits 7,6,5 of the program word ([2] is bit 7) |
| tick_i | input | 1 | Timebase tick enabling the algorithm counter |
| rd_i | input | 1 | Read strobe |
| rd_in_erase_i | input | 1 | Read address lies in a sector selected for erase |
| dq7_o | output | 1 | Poll bit / data bit 7 |
| dq6_o | output | 1 | Toggle bit / data bit 6 |
| dq5_o | output | 1 | Time-limit flag / data bit 5 |
| busy_o | output | 1 | Algorithm or protect window running |

## Verification
A wrong algorithm state appears on busy_o within one cycle of the accepted start. It also appears on dq7_o at the next read, because a program status inverts the latched bit and an erase status depends on the sector flag. A wrong tick counter shows up as busy_o falling one or more cycles early or late, and the bench compares that against its own tick count every cycle. A toggle register that was not cleared, or that was still advanced in read mode, shows on dq6_o at the first read of an operation or at the second read after completion. A wrong stored word shows at the first read after completion, and also after a protected operation that should have left the word unchanged.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_ERASE,
    ST_PROG_PROT,
    ST_ERASE_PROT
  } poll_state_e;

  localparam int unsigned HI_W = 3;  // data bits 7,6,5
endpackage

// File: rtl/flash_poll_timer.sv
module flash_poll_timer #(
  parameter int unsigned CNT_W       = 7,
  parameter int unsigned LIMIT_TICKS = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] target_i,
  output logic             done_o,
  output logic             timeout_o
);
  localparam logic [CNT_W-1:0] LIM_LAST = CNT_W'(LIMIT_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             to_q;
  logic             step;

  assign step      = run_i & tick_i & ~to_q;
  assign done_o    = step & ~hold_i & (cnt_q == target_i - 1'b1);
  assign timeout_o = to_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else if (clear_i) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else if (step) begin
      if (hold_i && cnt_q == LIM_LAST) to_q <= 1'b1;
      else                             cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/flash_poll_seq.sv
module flash_poll_seq
  import flash_poll_pkg::*;
#(
  parameter int unsigned CNT_W            = 7,
  parameter int unsigned PROG_TICKS       = 8,
  parameter int unsigned SECT_ERASE_TICKS = 20,
  parameter int unsigned CHIP_ERASE_TICKS = 40,
  parameter int unsigned PROT_PROG_TICKS  = 4,
  parameter int unsigned PROT_ERASE_TICKS = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            prog_start_i,
  input  logic            erase_start_i,
  input  logic            erase_chip_i,
  input  logic            sect_prot_i,
  input  logic            verify_fail_i,
  input  logic [HI_W-1:0] wdata_hi_i,
  input  logic            done_i,
  output poll_state_e     state_o,
  output logic            accept_o,
  output logic            busy_o,
  output logic            hold_o,
  output logic [CNT_W-1:0] target_o,
  output logic            pdata_msb_o,
  output logic [HI_W-1:0] mem_o
);
  localparam logic [CNT_W-1:0] T_PROG   = CNT_W'(PROG_TICKS);
  localparam logic [CNT_W-1:0] T_SECT   = CNT_W'(SECT_ERASE_TICKS);
  localparam logic [CNT_W-1:0] T_CHIP   = CNT_W'(CHIP_ERASE_TICKS);
  localparam logic [CNT_W-1:0] T_PPROG  = CNT_W'(PROT_PROG_TICKS);
  localparam logic [CNT_W-1:0] T_PERASE = CNT_W'(PROT_ERASE_TICKS);

  poll_state_e      state_q;
  logic [HI_W-1:0]  pdata_q;
  logic [HI_W-1:0]  mem_q;
  logic [CNT_W-1:0] target_q;

  assign accept_o    = (state_q == ST_IDLE) & (prog_start_i | erase_start_i);
  assign busy_o      = (state_q != ST_IDLE);
  assign hold_o      = verify_fail_i & ((state_q == ST_PROG) | (state_q == ST_ERASE));
  assign state_o     = state_q;
  assign target_o    = target_q;
  assign pdata_msb_o = pdata_q[HI_W-1];
  assign mem_o       = mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      pdata_q  <= '0;
      target_q <= '0;
      mem_q    <= '1;
    end else if (accept_o) begin
      if (prog_start_i) begin
        state_q  <= sect_prot_i ? ST_PROG_PROT : ST_PROG;
        pdata_q  <= wdata_hi_i;
        target_q <= sect_prot_i ? T_PPROG : T_PROG;
      end else begin
        state_q  <= sect_prot_i ? ST_ERASE_PROT : ST_ERASE;
        target_q <= sect_prot_i ? T_PERASE : (erase_chip_i ? T_CHIP : T_SECT);
      end
    end else if (done_i) begin
      state_q <= ST_IDLE;
      // protected windows leave the array untouched
      if (state_q == ST_PROG)       mem_q <= pdata_q;
      else if (state_q == ST_ERASE) mem_q <= '1;
    end
  end
endmodule

// File: rtl/flash_poll_readout.sv
module flash_poll_readout
  import flash_poll_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rd_i,
  input  logic            rd_in_erase_i,
  input  logic            accept_i,
  input  poll_state_e     state_i,
  input  logic            pdata_msb_i,
  input  logic [HI_W-1:0] mem_i,
  input  logic            timeout_i,
  output logic            dq7_o,
  output logic            dq6_o,
  output logic            dq5_o
);
  logic busy, prog_op, tgl_q;

  assign busy    = (state_i != ST_IDLE);
  assign prog_op = (state_i == ST_PROG) | (state_i == ST_PROG_PROT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               tgl_q <= 1'b0;
    else if (accept_i)         tgl_q <= 1'b0;
    else if (rd_i && busy)     tgl_q <= ~tgl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dq7_o <= 1'b0;
      dq6_o <= 1'b0;
      dq5_o <= 1'b0;
    end else if (rd_i) begin
      if (busy) begin
        dq7_o <= prog_op ? ~pdata_msb_i : ~rd_in_erase_i;
        dq6_o <= ~tgl_q;
        dq5_o <= timeout_i;
      end else begin
        dq7_o <= mem_i[2];
        dq6_o <= mem_i[1];
        dq5_o <= mem_i[0];
      end
    end
  end
endmodule

// File: rtl/flash_poll_status.sv
module flash_poll_status
  import flash_poll_pkg::*;
#(
  parameter int unsigned PROG_TICKS       = 8,
  parameter int unsigned SECT_ERASE_TICKS = 20,
  parameter int unsigned CHIP_ERASE_TICKS = 40,
  parameter int unsigned PROT_PROG_TICKS  = 4,
  parameter int unsigned PROT_ERASE_TICKS = 12,
  parameter int unsigned LIMIT_TICKS      = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        prog_start_i,
  input  logic        erase_start_i,
  input  logic        erase_chip_i,
  input  logic        sect_prot_i,
  input  logic        verify_fail_i,
  input  logic [2:0]  wdata_hi_i,
  input  logic        tick_i,
  input  logic        rd_i,
  input  logic        rd_in_erase_i,
  output logic        dq7_o,
  output logic        dq6_o,
  output logic        dq5_o,
  output logic        busy_o
);
  localparam int unsigned CNT_W = $clog2(LIMIT_TICKS + 1);

  poll_state_e      state;
  logic             accept, hold, done, timeout, pdata_msb;
  logic [CNT_W-1:0] target;
  logic [HI_W-1:0]  mem;

  flash_poll_seq #(
    .CNT_W           (CNT_W),
    .PROG_TICKS      (PROG_TICKS),
    .SECT_ERASE_TICKS(SECT_ERASE_TICKS),
    .CHIP_ERASE_TICKS(CHIP_ERASE_TICKS),
    .PROT_PROG_TICKS (PROT_PROG_TICKS),
    .PROT_ERASE_TICKS(PROT_ERASE_TICKS)
  ) i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .prog_start_i (prog_start_i),
    .erase_start_i(erase_start_i),
    .erase_chip_i (erase_chip_i),
    .sect_prot_i  (sect_prot_i),
    .verify_fail_i(verify_fail_i),
    .wdata_hi_i   (wdata_hi_i),
    .done_i       (done),
    .state_o      (state),
    .accept_o     (accept),
    .busy_o       (busy_o),
    .hold_o       (hold),
    .target_o     (target),
    .pdata_msb_o  (pdata_msb),
    .mem_o        (mem)
  );

  flash_poll_timer #(
    .CNT_W      (CNT_W),
    .LIMIT_TICKS(LIMIT_TICKS)
  ) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (accept),
    .run_i    (busy_o),
    .tick_i   (tick_i),
    .hold_i   (hold),
    .target_i (target),
    .done_o   (done),
    .timeout_o(timeout)
  );

  flash_poll_readout i_readout (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_i         (rd_i),
    .rd_in_erase_i(rd_in_erase_i),
    .accept_i     (accept),
    .state_i      (state),
    .pdata_msb_i  (pdata_msb),
    .mem_i        (mem),
    .timeout_i    (timeout),
    .dq7_o        (dq7_o),
    .dq6_o        (dq6_o),
    .dq5_o        (dq5_o)
  );
endmodule

// File: rtl/flash_poll_chk.sv
module flash_poll_chk
  import flash_poll_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        prog_start_i,
  input logic        erase_start_i,
  input logic        rd_i,
  input logic        dq7_o,
  input logic        dq6_o,
  input logic        dq5_o,
  input logic        busy_o,
  input poll_state_e state_i,
  input logic        timeout_i,
  input logic        pdata_msb_i
);
  assert_busy_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(prog_start_i | erase_start_i));

  assert_prog_poll_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (state_i == ST_PROG || state_i == ST_PROG_PROT)) |=> (dq7_o == !$past(pdata_msb_i)));

  assert_timeout_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_i |-> busy_o);

  assert_out_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable({dq7_o, dq6_o, dq5_o}));

  assert_no_restart_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_IDLE) |=> (state_i == $past(state_i) || state_i == ST_IDLE));
endmodule

bind flash_poll_status flash_poll_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .prog_start_i (prog_start_i),
  .erase_start_i(erase_start_i),
  .rd_i         (rd_i),
  .dq7_o        (dq7_o),
  .dq6_o        (dq6_o),
  .dq5_o        (dq5_o),
  .busy_o       (busy_o),
  .state_i      (state),
  .timeout_i    (timeout),
  .pdata_msb_i  (pdata_msb)
);

// File: tb/test_flash_poll_status.sv
`timescale 1ns/1ps
module test_flash_poll_status;
  localparam int P_PROG = 8, P_SECT = 20, P_CHIP = 40, P_PPROG = 4, P_PERASE = 12, P_LIM = 64;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic prog_start_i = 0, erase_start_i = 0, erase_chip_i = 0, sect_prot_i = 0, verify_fail_i = 0;
  logic [2:0] wdata_hi_i = '0;
  logic tick_i = 1, rd_i = 0, rd_in_erase_i = 0;
  logic dq7_o, dq6_o, dq5_o, busy_o;

  int n_chk = 0, n_fail = 0;
  bit fin = 0;
  logic [2:0] mem_exp = 3'b111;
  logic le7 = 0, le6 = 0, le5 = 0;

  always #2.5 clk_i = ~clk_i;

  flash_poll_status #(
    .PROG_TICKS(P_PROG), .SECT_ERASE_TICKS(P_SECT), .CHIP_ERASE_TICKS(P_CHIP),
    .PROT_PROG_TICKS(P_PPROG), .PROT_ERASE_TICKS(P_PERASE), .LIMIT_TICKS(P_LIM)
  ) i_flash_poll_status (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // kind: 0 program, 1 sector erase, 2 chip erase, 3 both starts (program wins)
  task automatic run_op(input int kind, input logic [2:0] d, input bit prot, input bit in_er,
                        input bit tick_alt, input bit intrude);
    int tgt, ticks, post;
    bit tg, rd_pend, is_prog, busy_exp;
    string tb, t7, td;
    is_prog = (kind == 0 || kind == 3);
    tgt = prot ? (is_prog ? P_PPROG : P_PERASE) : (kind == 2 ? P_CHIP : (kind == 1 ? P_SECT : P_PROG));
    tb = (kind == 3) ? "R2" : (intrude ? "R12" : (prot ? "R7" : "R6"));
    t7 = (kind == 3) ? "R2" : (intrude ? "R12" : (is_prog ? "R3" : "R4"));
    td = prot ? "R7" : "R8";
    prog_start_i = is_prog; erase_start_i = (kind != 0); erase_chip_i = (kind == 2);
    sect_prot_i = prot; wdata_hi_i = d; rd_in_erase_i = in_er; tick_i = 1;
    @(negedge clk_i);
    prog_start_i = 0; erase_start_i = 0; erase_chip_i = 0; wdata_hi_i = ~d;
    ticks = 0; post = 0; tg = 0; rd_pend = 0;
    for (int c = 1; c < 400; c++) begin
      if (rd_pend) begin
        chk((post >= 1) ? ((post == 2) ? td : "R9") : t7, dq7_o, le7);
        chk((post >= 1) ? "R9" : "R5", dq6_o, le6);
        chk((post >= 1) ? td : "R10", dq5_o, le5);
      end else begin
        chk("R11", {dq7_o, dq6_o, dq5_o}, {le7, le6, le5});
      end
      busy_exp = (ticks < tgt);
      chk(tb, busy_o, busy_exp);
      if (!busy_exp) begin
        post++;
        if (post == 1 && !prot) mem_exp = is_prog ? d : 3'b111;
      end
      if (post == 3) break;
      prog_start_i = 0; erase_start_i = 0;
      if (intrude && c == 2) begin
        prog_start_i = ~is_prog; erase_start_i = is_prog; erase_chip_i = 1;
        sect_prot_i = ~prot; wdata_hi_i = ~d;
      end
      rd_i = (c <= 3) || !busy_exp || (ticks == tgt - 1);
      rd_pend = rd_i;
      if (rd_i) begin
        if (busy_exp) begin
          tg = ~tg;
          le7 = is_prog ? ~d[2] : ~in_er;
          le6 = tg; le5 = 0;
        end else begin
          le7 = mem_exp[2]; le6 = mem_exp[1]; le5 = mem_exp[0];
        end
      end
      tick_i = tick_alt ? c[0] : 1'b1;
      if (busy_exp && tick_i) ticks++;
      @(negedge clk_i);
    end
    rd_i = 0; tick_i = 1; prog_start_i = 0; erase_start_i = 0; erase_chip_i = 0;
  endtask

  task automatic do_reset();
    rst_ni = 0; rd_i = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    mem_exp = 3'b111; le7 = 0; le6 = 0; le5 = 0;
    @(negedge clk_i);
  endtask

  initial begin
    #750000;
    if (!fin) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state, then a read returns all ones
    chk("R1", busy_o, 0);
    chk("R1", {dq7_o, dq6_o, dq5_o}, 0);
    rd_i = 1; @(negedge clk_i); rd_i = 0;
    chk("R1", {dq7_o, dq6_o, dq5_o}, 7);
    le7 = 1; le6 = 1; le5 = 1;

    // sweep program data x protect x tick pattern
    for (int dv = 0; dv < 8; dv++)
      for (int p = 0; p < 2; p++)
        for (int ta = 0; ta < 2; ta++)
          run_op(0, 3'(dv), p[0], 0, ta[0], 0);

    // erase sweeps, each preceded by program of 0 so the change is visible
    for (int k = 1; k < 3; k++)
      for (int p = 0; p < 2; p++)
        for (int ie = 0; ie < 2; ie++)
          for (int ta = 0; ta < 2; ta++) begin
            run_op(0, 3'b000, 0, 0, 0, 0);
            run_op(k, 3'b000, p[0], ie[0], ta[0], 0);
          end

    // both starts together: program wins (R2)
    run_op(3, 3'b010, 0, 1, 0, 0);
    run_op(3, 3'b101, 0, 1, 1, 0);
    // starts while busy ignored (R12)
    run_op(0, 3'b100, 0, 0, 0, 1);
    run_op(1, 3'b000, 0, 1, 0, 1);
    run_op(2, 3'b011, 1, 0, 0, 1);

    // protected ops ignore verify failure (R7)
    verify_fail_i = 1;
    run_op(0, 3'b000, 1, 0, 0, 0);
    run_op(1, 3'b000, 1, 1, 0, 0);

    // time-limit: unprotected program never verifies (R10)
    prog_start_i = 1; wdata_hi_i = 3'b100; sect_prot_i = 0;
    @(negedge clk_i);
    prog_start_i = 0;
    repeat (P_LIM - 1) @(negedge clk_i);
    rd_i = 1;
    @(negedge clk_i);
    chk("R10", dq5_o, 0);
    chk("R10", dq7_o, 0);
    chk("R5", dq6_o, 1);
    @(negedge clk_i);
    rd_i = 0;
    chk("R10", dq5_o, 1);
    chk("R5", dq6_o, 0);
    repeat (20) @(negedge clk_i);
    chk("R10", busy_o, 1);
    verify_fail_i = 0;
    do_reset();
    chk("R1", busy_o, 0);
    rd_i = 1; @(negedge clk_i); rd_i = 0;
    chk("R1", {dq7_o, dq6_o, dq5_o}, 7);

    fin = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule